// File: doc/BRIEF.md
# Core Interrupt Flag and Enable Controller

This block sits beside a CPU core and decides which maskable interrupt level the core should service next. Sixteen request lines set bits in a pending-flag register. Each pending bit is gated by a per-level enable register and by a global mask input. While the core is halted in real-time debug mode, a second, debug enable register also gates each level. Among the eligible levels the lowest-numbered one wins. Its index is offered to the core on a valid/ack handshake.

Software may also raise a level directly through a one-entry request port. Such a request is either a trap or an interrupt-instruction request. It is queued ahead of every hardware level and is offered regardless of the mask and enable bits. The acknowledge path decides which bits are cleared. A hardware acknowledge clears both the flag and the enable bit of that level. An interrupt-instruction acknowledge clears only the enable bit. A trap acknowledge clears nothing.

The vector output follows valid/ready rules with `irq_ack` as the ready. A transfer happens on a rising clock edge where both `irq_valid` and `irq_ack` are high. The transfer commits the index shown in that cycle. A hardware index may change, or valid may drop, before it is acknowledged, because a higher-priority level arrives or the mask changes. A software entry is held steady until it is taken. The software port accepts a request on a rising edge where `sw_valid` and `sw_ready` are both high. `sw_ready` stays low while an entry waits.

Top module: `irq_core_ctrl`

## Requirements
- R1: After reset the flag, enable and debug enable registers read 0, `irq_valid` is 0 and `sw_ready` is 1.
- R2: A 1 on `irq_req[i]` sets flag bit i at the next edge. A flag write (`reg_sel`=0, any `reg_op`) clears each bit where `reg_wdata` is 0 and leaves each bit where it is 1. If a request and a write-clear hit the same bit in one cycle, the bit ends up set.
- R3: Writes to the enable register (`reg_sel`=1) and to the debug enable register (`reg_sel`=2) use `reg_op` as follows: 0 loads `reg_wdata`, 1 ORs it in, 2 ANDs it in, 3 leaves the register unchanged.
- R4: A hardware level is offered only when its flag bit is 1, its enable bit is 1 and `intm` is 0. A level with its enable bit at 0 is never offered, whatever `intm` is.
- R5: When several hardware levels are eligible, `irq_index` gives the lowest-numbered one, and bit i maps to index i.
- R6: While `cpu_halted` and `rt_mode` are both 1, a hardware level must also have its debug enable bit at 1. Otherwise the debug enable register has no effect.
- R7: On an edge where a hardware level is offered and `irq_ack` is 1, that level's flag bit and enable bit are cleared. A request arriving on the same level in that cycle sets the flag again, and the acknowledge clear overrides an enable write in that cycle.
- R8: An accepted software request is offered with `irq_sw`=1 ahead of all hardware levels, regardless of flag, enable, debug enable and `intm`. When `sw_kind`=1 (interrupt instruction), its acknowledge clears the level's enable bit and leaves the flag bit unchanged.
- R9: When `sw_kind`=0 (trap), the acknowledge of the software request changes neither the flag nor the enable bit.
- R10: `sw_ready` is 1 exactly when no software entry is waiting. A request offered while an entry waits is not taken, and the waiting entry's index stays on `irq_index`.
- R11: `irq_ack` while `irq_valid` is 0 changes no register.
- R12: `reg_rdata` returns the register chosen by `reg_sel` (0 flag, 1 enable, 2 debug enable) in the same cycle. `reg_sel`=3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 16 | Hardware request per level; a 1 sets the flag bit |
| intm | input | 1 | Global mask; 1 blocks all hardware levels |
| cpu_halted | input | 1 | Core is halted |
| rt_mode | input | 1 | Core is in real-time debug mode |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 flag, 1 enable, 2 debug enable |
| reg_op | input | 2 | Write style: 0 load, 1 OR, 2 AND, 3 none |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| sw_valid | input | 1 | Software request offered |
| sw_ready | output | 1 | Software slot free |
| sw_level | input | 4 | Level of the software request |
| sw_kind | input | 1 | 1 interrupt instruction, 0 trap |
| irq_valid | output | 1 | A level is offered to the core |
| irq_index | output | 4 | Index of the offered level |
| irq_sw | output | 1 | Offered level comes from the software slot |
| irq_ack | input | 1 | Core takes the offered level |

## Verification
The checks assume that every input is a known value after reset and that `sw_level` stays below the number of levels. They place no limit on when `irq_ack`, requests, writes or mask changes may arrive. Because of this, the properties about clearing are written to allow a same-cycle request that sets a flag again, and they only compare the enable register on cycles with no register write. The random stimulus drives all inputs freely inside these limits, with occasional halt and debug-mode phases. Directed sequences cover set-versus-clear collisions, the three acknowledge paths and a software request offered while the slot is busy.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
  typedef enum logic [1:0] {
    REG_FLAG = 2'd0,
    REG_EN   = 2'd1,
    REG_DBG  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    WOP_LOAD = 2'd0,
    WOP_SET  = 2'd1,
    WOP_CLR  = 2'd2,
    WOP_NOP  = 2'd3
  } wr_op_e;

  typedef enum logic {
    SW_TRAP  = 1'b0,
    SW_INSTR = 1'b1
  } sw_kind_e;
endpackage

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int N_LVL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] set_i,
  input  logic             wr_en_i,
  input  logic [N_LVL-1:0] wr_keep_i,
  input  logic [N_LVL-1:0] ack_clr_i,
  output logic [N_LVL-1:0] q_o
);
  logic [N_LVL-1:0] keep;
  logic [N_LVL-1:0] nxt;

  // Write-zero-to-clear, then acknowledge clear, then hardware set has the last word
  always_comb begin
    keep = wr_en_i ? wr_keep_i : {N_LVL{1'b1}};
    nxt  = ((q_o & keep) & ~ack_clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_core_pkg::*;
#(
  parameter int N_LVL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  wr_op_e           wr_op_i,
  input  logic [N_LVL-1:0] wdata_i,
  input  logic [N_LVL-1:0] auto_clr_i,
  output logic [N_LVL-1:0] q_o
);
  logic [N_LVL-1:0] written;

  always_comb begin
    written = q_o;
    if (wr_en_i) begin
      unique case (wr_op_i)
        WOP_LOAD: written = wdata_i;
        WOP_SET:  written = q_o | wdata_i;
        WOP_CLR:  written = q_o & wdata_i;
        default:  written = q_o;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= written & ~auto_clr_i;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_LVL = 16,
  parameter int IDX_W = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_LVL:0]   blocked;
  logic [N_LVL-1:0] grant;

  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < N_LVL; g++) begin : g_chain
    assign grant[g]     = req_i[g] & ~blocked[g];
    assign blocked[g+1] = blocked[g] | req_i[g];
  end

  assign valid_o = blocked[N_LVL];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (grant[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_sw_slot.sv
module irq_sw_slot
  import irq_core_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [IDX_W-1:0] in_level_i,
  input  sw_kind_e         in_kind_i,
  input  logic             take_i,
  output logic             full_o,
  output logic [IDX_W-1:0] level_o,
  output sw_kind_e         kind_o
);
  assign in_ready_o = ~full_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_o  <= 1'b0;
      level_o <= '0;
      kind_o  <= SW_TRAP;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (in_valid_i && in_ready_o) begin
      full_o  <= 1'b1;
      level_o <= in_level_i;
      kind_o  <= in_kind_i;
    end
  end
endmodule

// File: rtl/irq_core_ctrl.sv
module irq_core_ctrl
  import irq_core_pkg::*;
#(
  parameter int N_LVL = 16,
  parameter int IDX_W = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] irq_req,
  input  logic             intm,
  input  logic             cpu_halted,
  input  logic             rt_mode,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [1:0]       reg_op,
  input  logic [N_LVL-1:0] reg_wdata,
  output logic [N_LVL-1:0] reg_rdata,
  input  logic             sw_valid,
  output logic             sw_ready,
  input  logic [IDX_W-1:0] sw_level,
  input  logic             sw_kind,
  output logic             irq_valid,
  output logic [IDX_W-1:0] irq_index,
  output logic             irq_sw,
  input  logic             irq_ack
);
  reg_sel_e         sel;
  wr_op_e           op;
  logic [N_LVL-1:0] flag_q, en_q, dbg_q;
  logic [N_LVL-1:0] eligible, dbg_gate, lvl_oh;
  logic [N_LVL-1:0] flag_ack_clr, en_auto_clr;
  logic             hw_valid, take, hw_take, sw_take;
  logic [IDX_W-1:0] hw_idx, slot_level;
  logic             slot_full;
  sw_kind_e         slot_kind;

  assign sel = reg_sel_e'(reg_sel);
  assign op  = wr_op_e'(reg_op);

  // Debug enables only matter while halted in real-time mode
  assign dbg_gate = (cpu_halted && rt_mode) ? dbg_q : {N_LVL{1'b1}};
  assign eligible = flag_q & en_q & dbg_gate & {N_LVL{~intm}};

  irq_prio_pick #(.N_LVL(N_LVL), .IDX_W(IDX_W)) u_pick (
    .req_i   (eligible),
    .valid_o (hw_valid),
    .idx_o   (hw_idx)
  );

  irq_sw_slot #(.IDX_W(IDX_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (sw_valid),
    .in_ready_o (sw_ready),
    .in_level_i (sw_level),
    .in_kind_i  (sw_kind_e'(sw_kind)),
    .take_i     (sw_take),
    .full_o     (slot_full),
    .level_o    (slot_level),
    .kind_o     (slot_kind)
  );

  // Software entry outranks every hardware level
  assign irq_valid = slot_full | hw_valid;
  assign irq_index = slot_full ? slot_level : hw_idx;
  assign irq_sw    = slot_full;

  assign take    = irq_valid & irq_ack;
  assign hw_take = take & ~slot_full;
  assign sw_take = take & slot_full;
  assign lvl_oh  = N_LVL'(1) << irq_index;

  assign flag_ack_clr = hw_take ? lvl_oh : '0;
  assign en_auto_clr  = (hw_take || (sw_take && slot_kind == SW_INSTR)) ? lvl_oh : '0;

  irq_flag_reg #(.N_LVL(N_LVL)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (irq_req),
    .wr_en_i   (reg_wr_en && sel == REG_FLAG),
    .wr_keep_i (reg_wdata),
    .ack_clr_i (flag_ack_clr),
    .q_o       (flag_q)
  );

  irq_mask_reg #(.N_LVL(N_LVL)) u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (reg_wr_en && sel == REG_EN),
    .wr_op_i    (op),
    .wdata_i    (reg_wdata),
    .auto_clr_i (en_auto_clr),
    .q_o        (en_q)
  );

  irq_mask_reg #(.N_LVL(N_LVL)) u_dbg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (reg_wr_en && sel == REG_DBG),
    .wr_op_i    (op),
    .wdata_i    (reg_wdata),
    .auto_clr_i ('0),
    .q_o        (dbg_q)
  );

  always_comb begin
    unique case (sel)
      REG_FLAG: reg_rdata = flag_q;
      REG_EN:   reg_rdata = en_q;
      REG_DBG:  reg_rdata = dbg_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_core_chk.sv
module irq_core_chk
  import irq_core_pkg::*;
#(
  parameter int N_LVL = 16,
  parameter int IDX_W = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_LVL-1:0] irq_req,
  input logic             intm,
  input logic             cpu_halted,
  input logic             rt_mode,
  input logic             reg_wr_en,
  input logic             sw_valid,
  input logic             sw_ready,
  input logic [IDX_W-1:0] sw_level,
  input logic             irq_valid,
  input logic [IDX_W-1:0] irq_index,
  input logic             irq_sw,
  input logic             irq_ack,
  input logic [N_LVL-1:0] flag_q,
  input logic [N_LVL-1:0] en_q,
  input logic [N_LVL-1:0] dbg_q,
  input sw_kind_e         slot_kind
);
  logic [N_LVL-1:0] below;
  assign below = (N_LVL'(1) << irq_index) - N_LVL'(1);

  p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_sw) |-> (!intm && flag_q[irq_index] && en_q[irq_index]));

  p_lowest_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_sw && !(cpu_halted && rt_mode)) |-> ((flag_q & en_q & below) == '0));

  p_debug_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_sw && cpu_halted && rt_mode) |-> dbg_q[irq_index]);

  p_hw_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && !irq_sw && !irq_req[irq_index])
      |=> (!flag_q[$past(irq_index)] && !en_q[$past(irq_index)]));

  p_instr_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && irq_sw && slot_kind == SW_INSTR) |=> !en_q[$past(irq_index)]);

  p_trap_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ack && irq_sw && slot_kind == SW_TRAP && !reg_wr_en)
      |=> (en_q == $past(en_q) && (flag_q & $past(flag_q)) == $past(flag_q)));

  p_sw_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && sw_ready) |=> (irq_valid && irq_sw && irq_index == $past(sw_level)));

  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && irq_ack && !reg_wr_en) |=> (en_q == $past(en_q)));
endmodule

bind irq_core_ctrl irq_core_chk #(.N_LVL(N_LVL), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .intm       (intm),
  .cpu_halted (cpu_halted),
  .rt_mode    (rt_mode),
  .reg_wr_en  (reg_wr_en),
  .sw_valid   (sw_valid),
  .sw_ready   (sw_ready),
  .sw_level   (sw_level),
  .irq_valid  (irq_valid),
  .irq_index  (irq_index),
  .irq_sw     (irq_sw),
  .irq_ack    (irq_ack),
  .flag_q     (flag_q),
  .en_q       (en_q),
  .dbg_q      (dbg_q),
  .slot_kind  (slot_kind)
);

// File: tb/sim_irq_core_ctrl.sv
module sim_irq_core_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0] irq_req, reg_wdata, reg_rdata;
  logic intm, cpu_halted, rt_mode, reg_wr_en, sw_valid, sw_ready, sw_kind;
  logic irq_valid, irq_sw, irq_ack;
  logic [1:0] reg_sel, reg_op;
  logic [3:0] sw_level, irq_index;

  irq_core_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .intm(intm),
    .cpu_halted(cpu_halted), .rt_mode(rt_mode), .reg_wr_en(reg_wr_en),
    .reg_sel(reg_sel), .reg_op(reg_op), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sw_valid(sw_valid), .sw_ready(sw_ready),
    .sw_level(sw_level), .sw_kind(sw_kind), .irq_valid(irq_valid),
    .irq_index(irq_index), .irq_sw(irq_sw), .irq_ack(irq_ack)
  );

  int errors = 0;
  int checks = 0;

  // Reference state
  logic [N-1:0] m_flag = '0, m_en = '0, m_dbg = '0;
  bit m_full = 0, m_kind = 0;
  int m_lvl = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void predict(output bit v, output int idx, output bit sw);
    logic [N-1:0] e;
    v = 0; idx = 0; sw = 0;
    if (m_full) begin
      v = 1; idx = m_lvl; sw = 1;
    end else begin
      e = m_flag & m_en;
      if (cpu_halted && rt_mode) e = e & m_dbg;
      if (intm) e = '0;
      for (int i = N - 1; i >= 0; i--) if (e[i]) begin v = 1; idx = i; end
    end
  endfunction

  function automatic logic [N-1:0] exp_rd();
    case (reg_sel)
      2'd0: return m_flag;
      2'd1: return m_en;
      2'd2: return m_dbg;
      default: return '0;
    endcase
  endfunction

  function automatic logic [N-1:0] apply_op(logic [N-1:0] cur);
    case (reg_op)
      2'd0: return reg_wdata;
      2'd1: return cur | reg_wdata;
      2'd2: return cur & reg_wdata;
      default: return cur;
    endcase
  endfunction

  task automatic idle();
    irq_req = '0; reg_wr_en = 0; reg_op = 0; reg_wdata = '0;
    sw_valid = 0; sw_level = 0; sw_kind = 0; irq_ack = 0;
  endtask

  // One clock: compare outputs, let the edge pass, advance the model
  task automatic cycle();
    bit v, sw, take;
    int idx;
    logic [N-1:0] f, e, d;
    #1;
    predict(v, idx, sw);
    chk("R4 irq_valid", int'(irq_valid), int'(v));
    if (v) chk("R5 irq_index", int'(irq_index), idx);
    chk("R8 irq_sw", int'(irq_sw), int'(sw));
    chk("R10 sw_ready", int'(sw_ready), int'(!m_full));
    chk("R12 reg_rdata", int'(reg_rdata), int'(exp_rd()));
    @(posedge clk);
    take = irq_ack && v;
    f = m_flag;
    if (reg_wr_en && reg_sel == 2'd0) f = f & reg_wdata;
    if (take && !sw) f[idx] = 1'b0;
    f = f | irq_req;
    e = m_en;
    if (reg_wr_en && reg_sel == 2'd1) e = apply_op(e);
    if (take && (!sw || m_kind)) e[idx] = 1'b0;
    d = m_dbg;
    if (reg_wr_en && reg_sel == 2'd2) d = apply_op(d);
    if (take && sw) m_full = 0;
    else if (sw_valid && !m_full) begin
      m_full = 1; m_lvl = int'(sw_level); m_kind = sw_kind;
    end
    m_flag = f; m_en = e; m_dbg = d;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [1:0] o, logic [N-1:0] w);
    reg_wr_en = 1; reg_sel = s; reg_op = o; reg_wdata = w;
    cycle();
    idle();
  endtask

  task automatic rd(logic [1:0] s, logic [N-1:0] exp, string tag);
    reg_sel = s;
    #1;
    chk(tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic see(bit v, int idx, string tag);
    #1;
    chk(tag, int'(irq_valid), int'(v));
    if (v) chk(tag, int'(irq_index), idx);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    idle(); intm = 0; cpu_halted = 0; rt_mode = 0; reg_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd0, 16'h0000, "R1 flag after reset");
    rd(2'd1, 16'h0000, "R1 enable after reset");
    rd(2'd2, 16'h0000, "R1 debug enable after reset");
    chk("R1 irq_valid after reset", int'(irq_valid), 0);
    chk("R1 sw_ready after reset", int'(sw_ready), 1);

    // R2 flag set and write-zero clear
    irq_req = 16'h0024; cycle(); idle();
    rd(2'd0, 16'h0024, "R2 request sets flags");
    wr(2'd0, 2'd0, 16'hFFFB);
    rd(2'd0, 16'h0020, "R2 zero write clears");
    irq_req = 16'h0020; reg_wr_en = 1; reg_sel = 2'd0; reg_wdata = 16'hFFDF;
    cycle(); idle();
    rd(2'd0, 16'h0020, "R2 set wins over clear");
    see(0, 0, "R4 disabled level not offered");

    // R3 enable write styles
    wr(2'd1, 2'd0, 16'h00F0); rd(2'd1, 16'h00F0, "R3 load");
    wr(2'd1, 2'd1, 16'h0003); rd(2'd1, 16'h00F3, "R3 or write");
    wr(2'd1, 2'd2, 16'hFFEF); rd(2'd1, 16'h00E3, "R3 and write");
    wr(2'd1, 2'd3, 16'h0000); rd(2'd1, 16'h00E3, "R3 op 3 no change");
    see(1, 5, "R4 eligible level offered");
    intm = 1; see(0, 0, "R4 global mask blocks"); cycle(); intm = 0;

    // R5 priority
    irq_req = 16'h0082; cycle(); idle();
    rd(2'd0, 16'h00A2, "R5 flags");
    see(1, 1, "R5 lowest level wins");

    // R6 debug gating
    cpu_halted = 1; rt_mode = 1;
    see(0, 0, "R6 halted with no debug enables");
    wr(2'd2, 2'd0, 16'h0080);
    see(1, 7, "R6 debug enabled level");
    rt_mode = 0; see(1, 1, "R6 halted outside rt mode");
    cpu_halted = 0; rt_mode = 1; see(1, 1, "R6 running ignores debug enables");
    rt_mode = 0;

    // R7 hardware acknowledge
    irq_ack = 1; cycle(); idle();
    rd(2'd0, 16'h00A0, "R7 flag cleared");
    rd(2'd1, 16'h00E1, "R7 enable cleared");
    see(1, 5, "R7 next level");

    // R11 ack with nothing offered
    intm = 1; irq_ack = 1; cycle(); idle(); intm = 0;
    rd(2'd0, 16'h00A0, "R11 flag unchanged");
    rd(2'd1, 16'h00E1, "R11 enable unchanged");

    // R8 interrupt-instruction request
    wr(2'd1, 2'd1, 16'h1000);
    intm = 1;
    sw_valid = 1; sw_level = 4'd12; sw_kind = 1; cycle();
    see(1, 12, "R8 software entry offered under mask");
    chk("R8 irq_sw", int'(irq_sw), 1);
    chk("R10 busy slot not ready", int'(sw_ready), 0);
    sw_level = 4'd3; sw_kind = 0; cycle(); idle();
    see(1, 12, "R10 busy slot keeps entry");
    intm = 0;
    irq_ack = 1; cycle(); idle();
    rd(2'd1, 16'h00E1, "R8 enable cleared");
    rd(2'd0, 16'h00A0, "R8 flag kept");
    chk("R8 slot freed", int'(irq_sw), 0);

    // R9 trap request
    sw_valid = 1; sw_level = 4'd5; sw_kind = 0; cycle(); idle();
    see(1, 5, "R9 trap offered");
    irq_ack = 1; cycle(); idle();
    rd(2'd1, 16'h00E1, "R9 enable kept");
    rd(2'd0, 16'h00A0, "R9 flag kept");

    // R12 unused select
    rd(2'd3, 16'h0000, "R12 select 3 reads 0");

    // Random phase against the model
    for (int n = 0; n < 3000; n++) begin
      irq_req   = N'($urandom & $urandom & $urandom);
      reg_wr_en = ($urandom % 5) == 0;
      reg_sel   = 2'($urandom);
      reg_op    = 2'($urandom);
      reg_wdata = N'($urandom);
      sw_valid  = ($urandom % 6) == 0;
      sw_level  = 4'($urandom);
      sw_kind   = 1'($urandom);
      irq_ack   = 1'($urandom);
      intm      = ($urandom % 5) == 0;
      if ((n % 50) == 0) begin
        cpu_halted = 1'($urandom);
        rt_mode    = 1'($urandom);
      end
      cycle();
    end
    idle();
    summary();
    $finish;
  end
endmodule